// File: doc/BRIEF.md
# Fan-out Decompressed Multi-chain Scan Array

This block is a scan test structure. A few tester input channels feed a larger set of internal scan chains of equal depth. Every storage bit is a mux-based scan cell. A scan-enable input chooses between two operations. With scan-enable high, each cell takes the bit of its upstream neighbour, so a test stimulus moves in while the previous response moves out at the chain tails. With scan-enable low, each cell loads the output of a small stand-in combinational function. The same behaviour serves as normal operation outside test.

Stimulus can be loaded in two ways, and both use the same cells. In fan-out mode, each tester channel drives the head of every chain in its group without change. The cells that lie the same distance from the input therefore always receive equal values within one group. In serial mode, the fan-out network is skipped and the chains are linked end to end into one long chain. This mode serves patterns that fan-out mode cannot encode. The selected mode is taken only on capture edges, so it stays fixed for the whole of a load. An internal counter raises a one-cycle done flag once a complete load has been shifted in. The tails of the chains leave the block raw, without compaction.

Top module: `scan_fanout_array`

## Requirements
- R1: After reset every scan cell holds 0, `chain_out` is all zeros, `load_done` is 0 and the load mode is fan-out.
- R2: On a clock edge with `scan_en` low, the cell at flat index i = k*DEPTH + p (chain k, position p, p = 0 at the head) loads `cell[i] ^ func_in[i]`.
- R3: On a clock edge with `scan_en` high, each cell at position p ≥ 1 loads the cell at position p−1 of the same chain, and `chain_out[k]` always shows the cell at position DEPTH−1 of chain k. One bit moves per clock.
- R4: In fan-out mode, a shift loads the head of chain k from `chan_in[k % CHANNELS]`. After any fan-out load, therefore, chains k and k % CHANNELS hold equal contents.
- R5: In serial mode, a shift loads the head of chain 0 from `chan_in[0]` and the head of chain k ≥ 1 from the tail of chain k−1. `chain_out[CHAINS-1]` is the serial output, and the bits of `chan_in` above bit 0 have no effect.
- R6: `mode_sel` (0 = fan-out, 1 = serial) is sampled only on edges with `scan_en` low. A change while `scan_en` is high is ignored until the next capture edge.
- R7: In fan-out mode, `load_done` is high for exactly the one cycle that follows the DEPTH-th consecutive shift edge.
- R8: In serial mode, `load_done` pulses after CHAINS*DEPTH consecutive shifts. The shift count restarts after each pulse and clears on any edge with `scan_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all cells |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | 1 = shift, 0 = capture / functional load |
| mode_sel | input | 1 | Requested load mode: 0 fan-out, 1 serial |
| chan_in | input | CHANNELS | Tester channels; bit 0 is also the serial input |
| func_in | input | CHAINS*DEPTH | Operand of the stand-in capture function |
| chain_out | output | CHAINS | Raw tail bit of each chain |
| load_done | output | 1 | One-cycle pulse when a full load has been shifted |

## Verification
Every result is a single register stage away from its cause. A shift or capture edge shows up on `chain_out` just after that same edge, and a bit entering at the head reaches the tail DEPTH edges later. The done flag is registered too, so it is high in the cycle that follows the edge completing the count. A change of the mode request takes effect only after the next edge with `scan_en` low. The bench drives every input at the falling edge and keeps a reference model of the cells, mode and count, which it advances by one edge per step. It compares the tails and the done flag 1 ns after each rising edge, so every expected value is sampled in the cycle in which it is due.

// File: rtl/scan_fo_pkg.sv
package scan_fo_pkg;
   typedef enum logic {
      LOAD_FANOUT = 1'b0,
      LOAD_SERIAL = 1'b1
   } load_mode_e;
endpackage

// File: rtl/scan_mode_reg.sv
module scan_mode_reg
   import scan_fo_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scan_en,
   input  logic       mode_req,
   output load_mode_e mode_q
);
   // Mode is only retaken on capture edges, so it is frozen across a load.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mode_q <= LOAD_FANOUT;
      else if (!scan_en) mode_q <= mode_req ? LOAD_SERIAL : LOAD_FANOUT;
   end
endmodule

// File: rtl/scan_shift_tally.sv
module scan_shift_tally
   import scan_fo_pkg::*;
#(
   parameter int CHAINS = 4,
   parameter int DEPTH  = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scan_en,
   input  load_mode_e mode,
   output logic       done
);
   localparam int TOTAL = CHAINS * DEPTH;
   localparam int CW    = $clog2(TOTAL + 1);
   localparam logic [CW-1:0] LAST_FO = CW'(DEPTH - 1);
   localparam logic [CW-1:0] LAST_SR = CW'(TOTAL - 1);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] last;

   assign last = (mode == LOAD_SERIAL) ? LAST_SR : LAST_FO;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         done  <= 1'b0;
      end else if (!scan_en) begin
         cnt_q <= '0;
         done  <= 1'b0;
      end else if (cnt_q == last) begin
         cnt_q <= '0;
         done  <= 1'b1;
      end else begin
         cnt_q <= cnt_q + 1'b1;
         done  <= 1'b0;
      end
   end
endmodule

// File: rtl/scan_head_feed.sv
module scan_head_feed
   import scan_fo_pkg::*;
#(
   parameter int CHANNELS = 2,
   parameter int CHAINS   = 4
) (
   input  load_mode_e          mode,
   input  logic [CHANNELS-1:0] chan_in,
   input  logic [CHAINS-1:0]   tails,
   output logic [CHAINS-1:0]   heads
);
   // Chain 0 takes channel 0 in both modes; the others choose by mode.
   assign heads[0] = chan_in[0];

   for (genvar k = 1; k < CHAINS; k++) begin : g_head
      localparam int GRP = k % CHANNELS;
      assign heads[k] = (mode == LOAD_SERIAL) ? tails[k-1] : chan_in[GRP];
   end

   logic unused_tail;
   assign unused_tail = tails[CHAINS-1];
endmodule

// File: rtl/scan_stand_in_logic.sv
module scan_stand_in_logic #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] state_in,
   input  logic [WIDTH-1:0] func_in,
   output logic [WIDTH-1:0] next_state
);
   // Placeholder for the circuit under test: bitwise toggle by operand.
   for (genvar i = 0; i < WIDTH; i++) begin : g_fn
      assign next_state[i] = state_in[i] ^ func_in[i];
   end
endmodule

// File: rtl/scan_cell_array.sv
module scan_cell_array #(
   parameter int CHAINS = 4,
   parameter int DEPTH  = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     scan_en,
   input  logic [CHAINS-1:0]        heads,
   input  logic [CHAINS*DEPTH-1:0]  capt,
   output logic [CHAINS*DEPTH-1:0]  cells,
   output logic [CHAINS-1:0]        tails
);
   for (genvar k = 0; k < CHAINS; k++) begin : g_chain
      for (genvar p = 0; p < DEPTH; p++) begin : g_cell
         localparam int IDX = k * DEPTH + p;
         logic shift_src;
         if (p == 0) begin : g_first
            assign shift_src = heads[k];
         end else begin : g_next
            assign shift_src = cells[IDX-1];
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cells[IDX] <= 1'b0;
            else        cells[IDX] <= scan_en ? shift_src : capt[IDX];
         end
      end
      assign tails[k] = cells[k*DEPTH + DEPTH - 1];
   end
endmodule

// File: rtl/scan_fanout_array.sv
module scan_fanout_array
   import scan_fo_pkg::*;
#(
   parameter int CHANNELS = 2,
   parameter int CHAINS   = 4,
   parameter int DEPTH    = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        scan_en,
   input  logic                        mode_sel,
   input  logic [CHANNELS-1:0]         chan_in,
   input  logic [CHAINS*DEPTH-1:0]     func_in,
   output logic [CHAINS-1:0]           chain_out,
   output logic                        load_done
);
   localparam int CELLS = CHAINS * DEPTH;

   if (CHANNELS < 1) begin : g_bad_ch
      $error("CHANNELS must be at least 1");
   end
   if (CHAINS % CHANNELS != 0) begin : g_bad_div
      $error("CHAINS must be a multiple of CHANNELS");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end

   load_mode_e          mode_q;
   logic [CHAINS-1:0]   heads;
   logic [CHAINS-1:0]   tails;
   logic [CELLS-1:0]    cells;
   logic [CELLS-1:0]    capt;

   scan_mode_reg u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .scan_en  (scan_en),
      .mode_req (mode_sel),
      .mode_q   (mode_q)
   );

   scan_head_feed #(.CHANNELS(CHANNELS), .CHAINS(CHAINS)) u_feed (
      .mode    (mode_q),
      .chan_in (chan_in),
      .tails   (tails),
      .heads   (heads)
   );

   scan_stand_in_logic #(.WIDTH(CELLS)) u_fn (
      .state_in   (cells),
      .func_in    (func_in),
      .next_state (capt)
   );

   scan_cell_array #(.CHAINS(CHAINS), .DEPTH(DEPTH)) u_cells (
      .clk     (clk),
      .rst_n   (rst_n),
      .scan_en (scan_en),
      .heads   (heads),
      .capt    (capt),
      .cells   (cells),
      .tails   (tails)
   );

   scan_shift_tally #(.CHAINS(CHAINS), .DEPTH(DEPTH)) u_tally (
      .clk     (clk),
      .rst_n   (rst_n),
      .scan_en (scan_en),
      .mode    (mode_q),
      .done    (load_done)
   );

   assign chain_out = tails;
endmodule

// File: rtl/scan_fanout_array_chk.sv
module scan_fanout_array_chk #(
   parameter int CHANNELS = 2,
   parameter int CHAINS   = 4,
   parameter int DEPTH    = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    scan_en,
   input logic                    mode_bit,
   input logic [CHANNELS-1:0]     chan_in,
   input logic [CHAINS*DEPTH-1:0] func_in,
   input logic [CHAINS*DEPTH-1:0] cells,
   input logic [CHAINS-1:0]       chain_out,
   input logic                    load_done
);
   assert_reset_clear_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> (cells == '0 && !load_done));

   assert_capture_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !scan_en |=> cells == ($past(cells) ^ $past(func_in)));

   assert_mode_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
      scan_en |=> $stable(mode_bit));

   assert_done_after_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
      load_done |-> $past(scan_en));

   for (genvar k = 0; k < CHAINS; k++) begin : g_k
      assert_tail_view_R3: assert property (@(posedge clk) disable iff (!rst_n)
         chain_out[k] == cells[k*DEPTH + DEPTH - 1]);
      for (genvar p = 1; p < DEPTH; p++) begin : g_p
         assert_shift_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
            scan_en |=> cells[k*DEPTH + p] == $past(cells[k*DEPTH + p - 1]));
      end
      if (k >= CHANNELS) begin : g_grp
         assert_fanout_equal_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (scan_en && !mode_bit) |=> cells[k*DEPTH] == cells[(k % CHANNELS)*DEPTH]);
      end
      if (k >= 1) begin : g_link
         assert_serial_link_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (scan_en && mode_bit) |=> cells[k*DEPTH] == $past(cells[(k-1)*DEPTH + DEPTH - 1]));
      end
   end

   assert_serial_head_R5: assert property (@(posedge clk) disable iff (!rst_n)
      scan_en |=> cells[0] == $past(chan_in[0]));
endmodule

bind scan_fanout_array scan_fanout_array_chk #(
   .CHANNELS(CHANNELS), .CHAINS(CHAINS), .DEPTH(DEPTH)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scan_en   (scan_en),
   .mode_bit  (mode_q),
   .chan_in   (chan_in),
   .func_in   (func_in),
   .cells     (cells),
   .chain_out (chain_out),
   .load_done (load_done)
);

// File: tb/scan_fanout_array_tb.sv
module scan_fanout_array_tb;
   localparam int C  = 2;
   localparam int N  = 4;
   localparam int D  = 4;
   localparam int ND = N * D;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          scan_en = 1'b0;
   logic          mode_sel = 1'b0;
   logic [C-1:0]  chan_in = '0;
   logic [ND-1:0] func_in = '0;
   logic [N-1:0]  chain_out;
   logic          load_done;

   int checks = 0;
   int errors = 0;

   // Reference model, built from the requirements.
   logic [ND-1:0] m_cells = '0;
   logic          m_mode = 1'b0;
   int            m_cnt = 0;
   logic          m_done = 1'b0;

   always #2 clk = ~clk;

   scan_fanout_array #(.CHANNELS(C), .CHAINS(N), .DEPTH(D)) u_dut (
      .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .mode_sel(mode_sel),
      .chan_in(chan_in), .func_in(func_in),
      .chain_out(chain_out), .load_done(load_done)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [N-1:0] model_tails();
      logic [N-1:0] t;
      for (int k = 0; k < N; k++) t[k] = m_cells[k*D + D - 1];
      return t;
   endfunction

   // One clock edge: drive at falling edge, advance model, sample after rise.
   task automatic step(input logic se, input logic sel, input logic [C-1:0] ch,
                       input logic [ND-1:0] fn, input string req);
      logic [ND-1:0] nxt;
      int lim;
      scan_en = se; mode_sel = sel; chan_in = ch; func_in = fn;
      if (!se) nxt = m_cells ^ fn;
      else begin
         for (int k = 0; k < N; k++) begin
            nxt[k*D] = (m_mode && k > 0) ? m_cells[(k-1)*D + D - 1] : ch[k % C];
            for (int p = 1; p < D; p++) nxt[k*D+p] = m_cells[k*D+p-1];
         end
      end
      lim = m_mode ? ND : D;
      if (!se) begin m_cnt = 0; m_done = 1'b0; end
      else if (m_cnt == lim - 1) begin m_cnt = 0; m_done = 1'b1; end
      else begin m_cnt++; m_done = 1'b0; end
      if (!se) m_mode = sel;
      @(posedge clk); #1;
      m_cells = nxt;
      check(chain_out == model_tails(), req, chain_out, model_tails());
      check(load_done == m_done, req, load_done, m_done);
      @(negedge clk);
   endtask

   task automatic t_reset();
      check(chain_out == '0, "R1", chain_out, 0);
      check(load_done == 1'b0, "R1", load_done, 0);
      // Mode must be fan-out: D shifts give done.
      for (int i = 0; i < D; i++) step(1'b1, 1'b1, 2'b01, '0, "R1");
      check(load_done == 1'b1, "R1", load_done, 1);
   endtask

   task automatic t_capture();
      step(1'b0, 1'b0, '0, 16'hA5C3, "R2");
      step(1'b0, 1'b0, '0, 16'h0F0F, "R2");
      for (int i = 0; i < D; i++) step(1'b1, 1'b0, '0, '0, "R3");
   endtask

   task automatic t_fanout();
      step(1'b0, 1'b0, '0, '0, "R4");
      for (int i = 0; i < D; i++) begin
         step(1'b1, 1'b0, C'($urandom), '0, "R7");
         check(load_done == (i == D - 1), "R7", load_done, (i == D - 1));
      end
      for (int i = 0; i < D; i++) begin
         for (int k = C; k < N; k++)
            check(chain_out[k] == chain_out[k % C], "R4", chain_out[k], chain_out[k % C]);
         step(1'b1, 1'b0, '0, '0, "R4");
      end
   endtask

   task automatic t_serial();
      logic [ND-1:0] pat;
      pat = 16'hC3A9;
      step(1'b0, 1'b1, '0, '0, "R5");
      for (int i = 0; i < ND; i++) begin
         step(1'b1, 1'b1, {1'($urandom), pat[i]}, '0, "R5");
         check(load_done == (i == ND - 1), "R8", load_done, (i == ND - 1));
      end
      // Unload: the first bit shifted in leaves first at the serial output.
      for (int i = 0; i < ND; i++) begin
         check(chain_out[N-1] == pat[i], "R5", chain_out[N-1], pat[i]);
         step(1'b1, 1'b1, 2'b10, '0, "R5");
      end
   endtask

   task automatic t_mode_ignore();
      step(1'b0, 1'b1, '0, '0, "R6");
      for (int i = 0; i < ND; i++) begin
         step(1'b1, (i > 2) ? 1'b0 : 1'b1, 2'b01, '0, "R6");
         check(load_done == (i == ND - 1), "R6", load_done, (i == ND - 1));
      end
      step(1'b0, 1'b0, '0, '0, "R6");
   endtask

   task automatic t_count_clear();
      step(1'b1, 1'b0, 2'b11, '0, "R8");
      step(1'b1, 1'b0, 2'b11, '0, "R8");
      step(1'b0, 1'b0, '0, '0, "R8");
      for (int i = 0; i < D; i++) begin
         step(1'b1, 1'b0, 2'b10, '0, "R8");
         check(load_done == (i == D - 1), "R8", load_done, (i == D - 1));
      end
      for (int i = 0; i < D; i++) begin
         step(1'b1, 1'b0, 2'b01, '0, "R8");
         check(load_done == (i == D - 1), "R8", load_done, (i == D - 1));
      end
   endtask

   bit finished = 1'b0;

   initial begin
      #40000;
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_capture();
      t_fanout();
      t_serial();
      t_mode_ignore();
      t_count_clear();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule